// File: doc/BRIEF.md
# I2C-Controlled Two-Channel Select Register

This block is an I2C slave that holds the one control register of a two-channel bus switch. It oversamples the SCL and SDA lines on the system clock. It matches a 7-bit slave address, formed from a fixed upper nibble and three pins. It drives SDA through an open-drain pull-down. After a matched write, it takes a control byte. That byte sets which downstream channel, if any, is connected.

A read returns the stored selection bits together with two live interrupt flags. Each flag is the inverse of an active-low interrupt input. The flags are captured at the moment a read byte is loaded for shifting out. A combined active-low interrupt output is low whenever either input is low.

A new selection never takes effect in the middle of a transfer. The channel that was connected stays connected until the STOP that closes the write.

Top module: `i2cChanSel`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1110 followed by `addrPins[2:1:0]`. It acknowledges by pulling SDA low for the whole high phase of the ninth SCL pulse. Bit 0 of the address byte selects the direction: 0 is write, 1 is read.
- R2: On an address mismatch the block never pulls SDA low. It ignores all further bits, including data bytes, until the next START or STOP, and `chanEn` is unchanged.
- R3: Every data byte of a matched write is acknowledged on the ninth SCL pulse.
- R4: During a write, `chanEn` keeps its previous value until the STOP that ends the transfer. It changes at no other time.
- R5: The control byte layout is: bit 0 is the channel choice, bit 1 is a spare select bit, and bit 2 is the enable. With bit 2 = 1, `chanEn` is 2'b01 when bit 0 = 0 and 2'b10 when bit 0 = 1. With bit 2 = 0, `chanEn` is 2'b00. At most one channel is enabled at a time.
- R6: A read byte is `{2'b00, ~irqInN[1], ~irqInN[0], 1'b0, b2, b1, b0}`. The low three bits are the stored register. The two flags are sampled when the byte is loaded, which is at the falling SCL edge that ends the preceding acknowledge. Bits 7, 6 and 3 read 0.
- R7: During a read, a master acknowledge (SDA low on the ninth pulse) makes the block send another byte. A master not-acknowledge makes the block release SDA and ignore the bus until STOP or START.
- R8: After reset, `chanEn` is 2'b00 and SDA is released.
- R9: `irqOutN` is low exactly when at least one bit of `irqInN` is low.
- R10: A START seen in the middle of a byte abandons it and restarts address decoding.
- R11: `sdaPullDown` changes only while SCL is low.
- R12: When a write carries several data bytes, the last acknowledged byte is the one applied at STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | I2C clock line as seen at the pin |
| sdaIn | input | 1 | I2C data line as seen at the pin |
| sdaPullDown | output | 1 | 1 pulls the SDA line low (open-drain) |
| addrPins | input | 3 | Low three bits of the slave address |
| irqInN | input | 2 | Active-low interrupt inputs, one per channel |
| irqOutN | output | 1 | Active-low combined interrupt |
| chanEn | output | 2 | One-hot (or zero) downstream channel enable |

## Verification
The bench builds the block with its default two-stage input synchroniser and the 1110 address prefix. It ties the address pins to 101, so the write address byte is 0xEA and the read address byte is 0xEB. Each SCL quarter period lasts six system clocks. This spacing gives room for the synchroniser delay, so the edges from the FSM land inside the low phase of SCL. The same spacing makes the SDA-stability rule observable at the bench's own pin model. Under these settings a mismatched address (0xE2) is reachable, as are multi-byte writes, acknowledged and unacknowledged reads with interrupt inputs that change between bytes, and a START cut into a half-sent byte.

// File: rtl/i2cChanSelPkg.sv
package i2cChanSelPkg;

  localparam int CH_COUNT = 2;
  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchPend;
    logic commit;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  // bus events and datapath status back to control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sclFall;
    logic sdaNow;
    logic sclNow;
    logic addrHit;
    logic rwBit;
    logic txMsb;
  } busEvent_t;

endpackage

// File: rtl/i2cChanSelData.sv
module i2cChanSelData
  import i2cChanSelPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b1110
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [2:0]          addrPins,
  input  logic [CH_COUNT-1:0] irqInN,
  input  dpStrobe_t           stb,
  output busEvent_t           ev,
  output logic [CH_COUNT-1:0] chanEn
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic [BYTE_BITS-1:0] rxShift, txShift;
  logic [2:0] pendReg, activeReg;
  logic pendValid;

  // input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync[0] <= 1'b1;
      sdaSync[0] <= 1'b1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
    end
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclSync[s] <= 1'b1;
        sdaSync[s] <= 1'b1;
      end else begin
        sclSync[s] <= sclSync[s-1];
        sdaSync[s] <= sdaSync[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync[LAST];
      sdaPrev <= sdaSync[LAST];
    end
  end

  assign ev.sclNow   = sclSync[LAST];
  assign ev.sdaNow   = sdaSync[LAST];
  assign ev.sclRise  = !sclPrev && sclSync[LAST];
  assign ev.sclFall  = sclPrev && !sclSync[LAST];
  assign ev.startDet = sclPrev && sclSync[LAST] && sdaPrev && !sdaSync[LAST];
  assign ev.stopDet  = sclPrev && sclSync[LAST] && !sdaPrev && sdaSync[LAST];
  assign ev.addrHit  = (rxShift[7:1] == {ADDR_PREFIX, addrPins});
  assign ev.rwBit    = rxShift[0];
  assign ev.txMsb    = txShift[BYTE_BITS-1];

  // shift registers and control storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '1;
      pendReg   <= '0;
      pendValid <= 1'b0;
      activeReg <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[BYTE_BITS-2:0], ev.sdaNow};
      if (stb.loadTx) txShift <= {2'b00, ~irqInN[1], ~irqInN[0], 1'b0, activeReg};
      else if (stb.shiftTx) txShift <= {txShift[BYTE_BITS-2:0], 1'b1};
      if (stb.latchPend) begin
        pendReg   <= rxShift[2:0];
        pendValid <= 1'b1;
      end else if (stb.commit && pendValid) begin
        activeReg <= pendReg;
        pendValid <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_chan
    assign chanEn[c] = activeReg[2] && (activeReg[0] == (c == 1));
  end

  p_chan_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanEn));

  p_chan_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanEn) |-> $past(ev.stopDet));

endmodule

// File: rtl/i2cChanSelCtrl.sv
module i2cChanSelCtrl
  import i2cChanSelPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvent_t ev,
  output dpStrobe_t stb,
  output logic      sdaPullDown
);

  busState_t state, nState;
  logic [3:0] bitCnt, nCnt;
  logic ackSeen, nAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackSeen <= 1'b0;
    end else begin
      state   <= nState;
      bitCnt  <= nCnt;
      ackSeen <= nAck;
    end
  end

  always_comb begin
    stb    = '0;
    nState = state;
    nCnt   = bitCnt;
    nAck   = ackSeen;
    if (ev.stopDet) begin
      stb.commit = 1'b1;
      nState     = ST_IDLE;
    end else if (ev.startDet) begin
      nState = ST_ADDR;
      nCnt   = '0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
            nCnt        = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            nState = ev.addrHit ? ST_ADDR_ACK : ST_IDLE;
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            nCnt = '0;
            if (ev.rwBit) begin
              nState     = ST_RD;
              stb.loadTx = 1'b1;
            end else begin
              nState = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (ev.sclRise) begin
            stb.shiftIn = 1'b1;
            nCnt        = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            stb.latchPend = 1'b1;
            nState        = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (ev.sclFall) begin
            nState = ST_WR;
            nCnt   = '0;
          end
        end
        ST_RD: begin
          if (ev.sclRise) begin
            nCnt = bitCnt + 4'd1;
          end else if (ev.sclFall) begin
            if (bitCnt == 4'd8) nState = ST_RD_ACK;
            else stb.shiftTx = 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (ev.sclRise) begin
            nAck = !ev.sdaNow;
          end else if (ev.sclFall) begin
            if (ackSeen) begin
              nState     = ST_RD;
              stb.loadTx = 1'b1;
              nCnt       = '0;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullDown = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                       (state == ST_RD && !ev.txMsb);

  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullDown) |-> !ev.sclNow);

  p_nack_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_ACK && ev.sclFall && !ackSeen && !ev.startDet && !ev.stopDet)
      |=> (state == ST_IDLE && !sdaPullDown));

  p_mismatch_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && ev.sclFall && bitCnt == 4'd8 && !ev.addrHit &&
     !ev.startDet && !ev.stopDet) |=> !sdaPullDown);

endmodule

// File: rtl/i2cChanSel.sv
module i2cChanSel
  import i2cChanSelPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_PREFIX = 4'b1110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullDown,
  input  logic [2:0] addrPins,
  input  logic [1:0] irqInN,
  output logic       irqOutN,
  output logic [1:0] chanEn
);

  dpStrobe_t stb;
  busEvent_t ev;

  i2cChanSelData #(
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_PREFIX(ADDR_PREFIX)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .addrPins(addrPins),
    .irqInN(irqInN),
    .stb(stb),
    .ev(ev),
    .chanEn(chanEn)
  );

  i2cChanSelCtrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .ev(ev),
    .stb(stb),
    .sdaPullDown(sdaPullDown)
  );

  assign irqOutN = &irqInN;

  p_irq_combine_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOutN == 1'b0) == (irqInN != 2'b11));

endmodule

// File: tb/i2cChanSel_tb.sv
module i2cChanSel_tb;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic [1:0] irq = 2'b11;
  logic [2:0] pins = 3'b101;
  logic sdaPullDown, irqOutN;
  logic [1:0] chanEn;
  wire sdaBus = sdaM & ~sdaPullDown;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit inStop = 0;
  bit pendValid = 0;
  logic [7:0] pendByte = '0;
  logic [1:0] modelChan = 2'b00;
  logic pullPrev = 1'b0;
  logic [7:0] got;
  logic ackBit;

  always #5 clk = ~clk;

  i2cChanSel u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaPullDown(sdaPullDown), .addrPins(pins), .irqInN(irq),
    .irqOutN(irqOutN), .chanEn(chanEn)
  );

  function automatic logic [1:0] decode(input logic [7:0] b);
    if (!b[2]) return 2'b00;
    return b[0] ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock reference comparison, sampled between edges
  always @(posedge clk) begin
    #3;
    if (rstN && !done) begin
      if (!inStop) chk("R4 chanEn vs model", {6'd0, chanEn}, {6'd0, modelChan});
      chk("R9 irqOutN", {7'd0, irqOutN}, {7'd0, &irq});
      if (scl) chk("R11 sda steady while scl high", {7'd0, sdaPullDown}, {7'd0, pullPrev});
    end
    pullPrev = sdaPullDown;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    inStop = 1'b1;
    sdaM = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
    if (pendValid) modelChan = decode(pendByte);
    pendValid = 1'b0;
    inStop = 1'b0;
    waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic wrByte(input logic [7:0] b, input logic expAck, input bit isData, input string req);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    ackBit = sdaBus;
    chk(req, {7'd0, ackBit}, {7'd0, ~expAck});
    waitQ();
    scl = 1'b0; waitQ();
    if (isData && expAck) begin
      pendByte = b;
      pendValid = 1'b1;
    end
  endtask

  task automatic rdByte(output logic [7:0] b, input bit giveAck, input logic [1:0] irqNext);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitQ();
      scl = 1'b1; waitQ();
      b[i] = sdaBus;
      waitQ();
      scl = 1'b0; waitQ();
    end
    irq = irqNext;
    sdaM = giveAck ? 1'b0 : 1'b1; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0;
    sdaM = 1'b1; waitQ();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 reset chanEn", {6'd0, chanEn}, 8'h00);
    chk("R8 reset sda released", {7'd0, sdaPullDown}, 8'h00);
    chk("R9 idle irqOutN", {7'd0, irqOutN}, 8'h01);

    // select channel 0
    startCond();
    wrByte(8'hEA, 1'b1, 1'b0, "R1 write address ack");
    wrByte(8'h04, 1'b1, 1'b1, "R3 data ack");
    chk("R4 previous channel kept before stop", {6'd0, chanEn}, 8'h00);
    stopCond();
    chk("R5 enable with bit0=0", {6'd0, chanEn}, 8'h01);

    // select channel 1
    startCond();
    wrByte(8'hEA, 1'b1, 1'b0, "R1 write address ack");
    wrByte(8'h05, 1'b1, 1'b1, "R3 data ack");
    chk("R4 channel 0 kept until stop", {6'd0, chanEn}, 8'h01);
    stopCond();
    chk("R5 enable with bit0=1", {6'd0, chanEn}, 8'h02);

    // wrong address
    startCond();
    wrByte(8'hE2, 1'b0, 1'b0, "R2 mismatch no ack");
    wrByte(8'h00, 1'b0, 1'b0, "R2 data ignored after mismatch");
    stopCond();
    chk("R2 chanEn unchanged", {6'd0, chanEn}, 8'h02);

    // several bytes, last wins
    startCond();
    wrByte(8'hEA, 1'b1, 1'b0, "R1 write address ack");
    wrByte(8'h00, 1'b1, 1'b1, "R3 first data ack");
    wrByte(8'h04, 1'b1, 1'b1, "R3 second data ack");
    chk("R4 unchanged mid write", {6'd0, chanEn}, 8'h02);
    stopCond();
    chk("R12 last byte applied", {6'd0, chanEn}, 8'h01);

    // enable cleared
    startCond();
    wrByte(8'hEA, 1'b1, 1'b0, "R1 write address ack");
    wrByte(8'h01, 1'b1, 1'b1, "R3 data ack");
    stopCond();
    chk("R5 enable off", {6'd0, chanEn}, 8'h00);

    // store 0x05, then read with interrupts
    startCond();
    wrByte(8'hEA, 1'b1, 1'b0, "R1 write address ack");
    wrByte(8'h05, 1'b1, 1'b1, "R3 data ack");
    stopCond();
    irq = 2'b10;
    repeat (2) @(negedge clk);
    chk("R9 irqOutN asserted", {7'd0, irqOutN}, 8'h00);
    startCond();
    wrByte(8'hEB, 1'b1, 1'b0, "R1 read address ack");
    rdByte(got, 1'b1, 2'b01);
    chk("R6 read byte with INT0", got, 8'h15);
    rdByte(got, 1'b0, 2'b01);
    chk("R7 second byte after ack, INT1", got, 8'h25);
    chk("R7 sda released after nack", {7'd0, sdaPullDown}, 8'h00);
    chk("R7 bus high after nack", {7'd0, sdaBus}, 8'h01);
    stopCond();

    // all bits set, unused bits read zero
    irq = 2'b11;
    startCond();
    wrByte(8'hEA, 1'b1, 1'b0, "R1 write address ack");
    wrByte(8'hFF, 1'b1, 1'b1, "R3 data ack");
    stopCond();
    chk("R5 all ones selects channel 1", {6'd0, chanEn}, 8'h02);
    startCond();
    wrByte(8'hEB, 1'b1, 1'b0, "R1 read address ack");
    rdByte(got, 1'b0, 2'b11);
    chk("R6 unused bits zero", got, 8'h07);
    stopCond();

    // repeated start cuts a half byte
    startCond();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    startCond();
    wrByte(8'hEB, 1'b1, 1'b0, "R10 address after repeated start");
    rdByte(got, 1'b0, 2'b00);
    chk("R10 read after repeated start", got, 8'h07);
    stopCond();
    chk("R9 both interrupts", {7'd0, irqOutN}, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule